// File: doc/BRIEF.md
# Chip-select framed serial command receiver

This block receives 16-bit command frames over a three-wire serial link made of an active-low select, a serial clock and a data line. All three pins are brought into the system clock domain first. While select is held low, each rising serial clock edge shifts one data bit into a frame register, most significant bit first. A frame carries a 6-bit command, then an 8-bit data byte, then two trailing sub-bits that are expected to be zero.

Nothing reaches the outputs while bits are still arriving. The frame is committed only when select returns high, and only if exactly sixteen serial clock rising edges were seen since select fell. On a commit, the command and data outputs load and a one-cycle update strobe fires in the same cycle. Short frames, long frames and frames sent while the interface is deselected by the mode input are dropped, and the outputs keep their previous values. A parent block can therefore merge these outputs with those of another serial front end into one register bank, using the mode input to pick which front end is active. The receiver has no power state of its own, so it stays fully active whenever the mode input selects it.

Top module: `spi_cmd_latch`

## Requirements
- R1: After synchronous reset, `cmd_o` and `data_o` are zero and `upd_o` is low.
- R2: Bits are taken from `din` on rising `sclk` edges while `cs_n` is low, first bit first. In a committed frame, bits 1 to 6 form `cmd_o` (first bit is its MSB) and bits 7 to 14 form `data_o` (bit 7 is its MSB).
- R3: `upd_o` is high for exactly one system clock cycle per committed frame. `cmd_o` and `data_o` change only in that cycle.
- R4: A frame with fewer than 16 rising `sclk` edges between the falling and the rising of `cs_n` is discarded: there is no strobe and the outputs do not change.
- R5: A frame with more than 16 rising `sclk` edges while `cs_n` is low is discarded, even though the first 16 bits were well formed.
- R6: Bits 15 and 16 of a frame (the sub-bits) have no effect on `cmd_o` or `data_o`, whatever their values.
- R7: While `mode_spi` is low, no frame is committed and the outputs hold. A frame sent after `mode_spi` returns high is accepted normally.
- R8: `sclk` edges while `cs_n` is high do not count toward the next frame.
- R9: A discarded frame does not affect the next frame. The bit count restarts on every falling edge of `cs_n`.
- R10: `cs_n` is driven in step with the system clock. When it rises at the end of a valid frame, `upd_o` is high at the third sampling point after the change (two synchronizer stages plus one edge register) and low at the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_spi | input | 1 | High selects this serial front end |
| cs_n | input | 1 | Active-low frame select pin (asynchronous) |
| sclk | input | 1 | Serial clock pin (asynchronous) |
| din | input | 1 | Serial data pin (asynchronous) |
| cmd_o | output | 6 | Last committed command field |
| data_o | output | 8 | Last committed data byte |
| upd_o | output | 1 | One-cycle strobe marking a commit |

## Verification
A wrong bit count at the moment `cs_n` rises shows up at once. Either a strobe appears for a frame that should have been dropped, or a good frame gives no strobe, and in both cases the error is visible three cycles after select is released. A misaligned shift register or a wrong field slice does not change the strobe timing, but it shows in the values of `cmd_o` and `data_o` in the same cycle as the strobe. The bench therefore compares both fields on every commit, using frames whose commands, data and sub-bits differ from frame to frame. Counter state that is not cleared between frames only shows up in the frame that follows, so every discarded frame is followed immediately by a good one.

// File: rtl/spi_latch_pkg.sv
package spi_latch_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_W      = 6;
    localparam int DATA_W     = 8;
    localparam int SUB_W      = FRAME_BITS - CMD_W - DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // control lanes that need edge detection
    localparam int CTL_LANES  = 2;
    localparam int IDX_CS     = 0;
    localparam int IDX_SCLK   = 1;
    localparam logic [CTL_LANES-1:0] CTL_IDLE = CTL_LANES'(1) << IDX_CS;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic [SUB_W-1:0]  sub;
    } frame_t;

    function automatic frame_t split_frame(input logic [FRAME_BITS-1:0] word);
        return frame_t'(word);
    endfunction

    function automatic logic frame_complete(input logic [CNT_W-1:0] cnt,
                                            input logic              over);
        return (cnt == CNT_W'(FRAME_BITS)) && !over;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [W-1:0] r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) r <= RST_VAL;
                    else     r <= g_stage[s-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_toggle_det.sv
module spi_toggle_det #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] tog
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign tog = lvl ^ prev;
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
    import spi_latch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] word,
    output logic [CNT_W-1:0]      cnt,
    output logic                  over
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
            over <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            over <= 1'b0;
        end else if (shift_en) begin
            word <= {word[FRAME_BITS-2:0], bit_in};
            if (cnt == CNT_W'(FRAME_BITS)) over <= 1'b1;
            else                           cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_cmd_latch.sv
module spi_cmd_latch
    import spi_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_spi,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o,
    output logic              upd_o
);
    logic [CTL_LANES-1:0] ctl_raw, ctl_lvl, ctl_tog;
    logic                 din_s;
    logic                 cs_rise, cs_fall, sclk_rise, sel_low;
    logic [FRAME_BITS-1:0] shift_word;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 bit_over;
    logic                 accept;
    frame_t               frame;

    assign ctl_raw[IDX_CS]   = cs_n;
    assign ctl_raw[IDX_SCLK] = sclk;

    spi_pin_sync #(.W(CTL_LANES), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_lvl)
    );

    spi_pin_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din_sync (
        .clk(clk), .rst(rst), .d(din), .q(din_s)
    );

    spi_toggle_det #(.W(CTL_LANES), .RST_VAL(CTL_IDLE)) u_edges (
        .clk(clk), .rst(rst), .lvl(ctl_lvl), .tog(ctl_tog)
    );

    assign cs_rise   = ctl_tog[IDX_CS]   &  ctl_lvl[IDX_CS];
    assign cs_fall   = ctl_tog[IDX_CS]   & ~ctl_lvl[IDX_CS];
    assign sclk_rise = ctl_tog[IDX_SCLK] &  ctl_lvl[IDX_SCLK];
    assign sel_low   = ~ctl_lvl[IDX_CS] & mode_spi;

    spi_frame_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear   (cs_fall | ~mode_spi),
        .shift_en(sclk_rise & sel_low),
        .bit_in  (din_s),
        .word    (shift_word),
        .cnt     (bit_cnt),
        .over    (bit_over)
    );

    assign frame  = split_frame(shift_word);
    assign accept = cs_rise & mode_spi & frame_complete(bit_cnt, bit_over);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o  <= '0;
            data_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= accept;
            if (accept) begin
                cmd_o  <= frame.cmd;
                data_o <= frame.data;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_latch_chk.sv
module spi_cmd_latch_chk
    import spi_latch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_spi,
    input logic              upd,
    input logic [CMD_W-1:0]  cmd,
    input logic [DATA_W-1:0] data,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              cs_rise
);
    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd); // R3

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd |-> ($stable(cmd) && $stable(data))); // R3

    AST_UPD_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
        upd |-> ($past(bit_cnt) == CNT_W'(FRAME_BITS))); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS)); // R5

    AST_UPD_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        upd |-> $past(mode_spi)); // R7

    AST_UPD_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
        upd |-> $past(cs_rise)); // R10
endmodule

bind spi_cmd_latch spi_cmd_latch_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_spi(mode_spi),
    .upd     (upd_o),
    .cmd     (cmd_o),
    .data    (data_o),
    .bit_cnt (bit_cnt),
    .cs_rise (cs_rise)
);

// File: tb/spi_cmd_latch_tb.sv
module spi_cmd_latch_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_spi = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [5:0] cmd_o;
    logic [7:0] data_o;
    logic       upd_o;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    int accepted = 0;
    logic [5:0] exp_cmd = '0;
    logic [7:0] exp_data = '0;

    always #5 clk = ~clk;

    spi_cmd_latch u_dut (
        .clk(clk), .rst(rst), .mode_spi(mode_spi), .cs_n(cs_n),
        .sclk(sclk), .din(din), .cmd_o(cmd_o), .data_o(data_o), .upd_o(upd_o)
    );

    always @(posedge clk) if (!rst && upd_o) strobes++;

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [15:0] w, int nbits);
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 16) ? w[15-i] : 1'b1;
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
        end
        tick(4);
    endtask

    task automatic release_check(bit ok, string req);
        int hits = 0;
        int pos = 0;
        cs_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            if (upd_o) begin
                hits++;
                pos = k;
            end
        end
        if (ok) begin
            accepted++;
            check(req, "strobe count", hits, 1);
            check("R10", "strobe position", pos, 3);
        end else begin
            check(req, "strobe count", hits, 0);
        end
        check(req, "cmd", int'(cmd_o), int'(exp_cmd));
        check(req, "data", int'(data_o), int'(exp_data));
        tick(4);
    endtask

    task automatic frame_ok(logic [5:0] c, logic [7:0] d, logic [1:0] s, string req);
        send_bits({c, d, s}, 16);
        exp_cmd = c;
        exp_data = d;
        release_check(1'b1, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check("R1", "cmd", int'(cmd_o), 0);
        check("R1", "data", int'(data_o), 0);
        check("R1", "upd", int'(upd_o), 0);

        // R2 R6: every command code, data and sub-bits derived arithmetically
        for (int c = 0; c < 64; c++) begin
            frame_ok(6'(c), 8'((c * 53 + 17) % 256), 2'(c % 4), "R2");
        end
        // R2 R6: every data byte, sub-bits nonzero
        for (int d = 0; d < 256; d++) begin
            frame_ok(6'((d * 7 + 3) % 64), 8'(d), 2'((d + 1) % 4), "R6");
        end

        // R4: short frames of several lengths, each followed by a good frame (R9)
        for (int n = 0; n < 16; n += 5) begin
            send_bits(16'hFFFF, n);
            release_check(1'b0, "R4");
            frame_ok(6'h15, 8'h5A, 2'b00, "R9");
        end
        send_bits(16'hFFFF, 15);
        release_check(1'b0, "R4");

        // R5: too many clocks, then recovery (R9)
        send_bits(16'h3C81, 17);
        release_check(1'b0, "R5");
        send_bits(16'h0F0F, 20);
        release_check(1'b0, "R5");
        frame_ok(6'h2A, 8'hC3, 2'b11, "R9");

        // R8: clock edges with select high are not counted
        din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        frame_ok(6'h01, 8'h80, 2'b01, "R8");

        // R7: mode low blocks commits
        mode_spi = 1'b0;
        tick(4);
        send_bits({6'h3F, 8'hFF, 2'b00}, 16);
        release_check(1'b0, "R7");
        mode_spi = 1'b1;
        tick(4);
        frame_ok(6'h12, 8'h34, 2'b00, "R7");

        // R3 strobe total matches accepted frames
        check("R3", "strobe total", strobes, accepted);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule